// File: doc/BRIEF.md
# Flash Controller FIFO Status and Interrupt Unit

This block sits on the host side of a serial flash controller. It holds a transmit FIFO and a receive FIFO behind one data register. It reports their fill state in a FIFO status word and the sequencer's busy state in a separate status word. It also keeps an eight-source interrupt scheme with sticky raw bits, a mask, a write-one-to-clear register and a single interrupt line. Software reaches it through a simple single-cycle word register bus. Writes take effect at the clock edge, and read data is combinational while `bus_en` is high with `bus_we` low.

The serial sequencer is represented only by its stream handshakes and a few strobes. It drains the transmit FIFO through a valid/ready output stream and fills the receive FIFO through a valid/ready input stream. A word moves on a stream only in a cycle where both valid and ready are high. The unit holds `tx_valid` and `tx_data` steady until the word is taken, unless a soft reset flushes the FIFO. `rx_ready` drops while the receive FIFO is full or a soft reset is running, so the sequencer must hold its word until it is accepted. A self-clearing soft reset flushes both FIFOs and wipes the raw interrupt state. The global control word is protected against changes while the sequencer reports busy.

Top module: `fstat_unit`

## Requirements
- R1: The FIFO status word at byte offset 0x20 carries the receive level in bits 20:16 and the transmit free space (DEPTH minus the words held) in bits 12:8. Bit 3 is receive full, bit 2 is receive empty, bit 1 is transmit empty and bit 0 is transmit full. All other bits read 0.
- R2: A bus write to offset 0x108 appends the word to the transmit FIFO, and the words leave on the transmit stream in write order. A bus read of 0x108 returns and removes the oldest receive word, in arrival order.
- R3: `tx_valid` is high exactly when the transmit FIFO holds a word and no soft reset runs. `rx_ready` is high exactly when the receive FIFO is not full and no soft reset runs. A word moves only when valid and ready are both high.
- R4: A data write while the transmit FIFO is full discards the word, leaves the FIFO unchanged and sets raw interrupt bit 2.
- R5: A data read while the receive FIFO is empty returns 0, leaves the FIFO unchanged and sets raw interrupt bit 1.
- R6: The raw interrupt word at 0x28 latches these events until cleared:
  - bit 7: `dma_done` pulse
  - bit 6: `ser_err` pulse
  - bit 5: `hbus_err` pulse
  - bit 4: `xfer_done` pulse
  - bit 3: the transmit stream takes the last word
  - bit 0: the receive stream fills the FIFO
- R7: Writing to offset 0x08 clears every raw bit written as 1, so writing all ones clears all of them. A bit whose event fires in the same cycle stays set.
- R8: The mask word at 0x04 resets to 0xFF, and a mask bit of 1 hides that source. The masked status at 0x1C equals raw AND NOT mask. `irq` is high when any masked bit is set.
- R9: Bit 0 of the status word at 0x24 follows `seq_busy`.
- R10: The control word at 0x00 stores a bus write and reads back. A write made while `seq_busy` is high has no effect.
- R11: Writing 1 to bit 0 of offset 0x10 starts a soft reset. Bit 0 of that offset reads 1 for RST_CYCLES cycles and then 0. Afterwards both FIFOs are empty and the raw word is 0, while mask and control keep their values.
- R12: Offsets not named above read 0, and writes to them have no effect on any readable state.
- R13: After reset the FIFO status shows both FIFOs empty with the full DEPTH free. The raw word reads 0, the mask reads 0xFF and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tx_valid | output | 1 | Transmit FIFO offers a word |
| tx_ready | input | 1 | Sequencer takes the offered word |
| tx_data | output | 32 | Oldest transmit word |
| rx_valid | input | 1 | Sequencer offers a received word |
| rx_ready | output | 1 | Receive FIFO accepts the word |
| rx_data | input | 32 | Received word |
| seq_busy | input | 1 | Sequencer busy level |
| xfer_done | input | 1 | Transfer-finished pulse |
| dma_done | input | 1 | DMA-finished pulse |
| ser_err | input | 1 | Serial error pulse |
| hbus_err | input | 1 | Host bus error pulse |
| irq | output | 1 | OR of the unmasked raw interrupts |

## Verification
The bench builds the unit with DEPTH = 4 and RST_CYCLES = 3. The shallow FIFOs mean random traffic hits the full and empty edges often, so overflow, underflow, last-word-out and fill-to-full events each occur many times. The short reset window lets the bench check every cycle of the recovery read-back exactly. The field positions of the status word stay fixed, so the level fields are still checked at their real bit places, only with smaller values.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 9;
  localparam int IRQ_N  = 8;
  localparam int LVL_FW = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_RECOV = 9'h010;
  localparam logic [ADDR_W-1:0] OFS_ISR   = 9'h01C;
  localparam logic [ADDR_W-1:0] OFS_FSR   = 9'h020;
  localparam logic [ADDR_W-1:0] OFS_SR    = 9'h024;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 9'h028;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 9'h108;

  localparam int FSR_RXLVL_LSB = 16;
  localparam int FSR_TXLVL_LSB = 8;

  localparam int IRQ_RX_FULL  = 0;
  localparam int IRQ_RX_UNDER = 1;
  localparam int IRQ_TX_OVER  = 2;
  localparam int IRQ_TX_EMPTY = 3;
  localparam int IRQ_XFER     = 4;
  localparam int IRQ_HBUS     = 5;
  localparam int IRQ_SERIAL   = 6;
  localparam int IRQ_DMA      = 7;
endpackage

// File: rtl/fstat_fifo.sv
module fstat_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R4
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/fstat_irq.sv
module fstat_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         wipe,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '1;
    end else begin
      raw <= wipe ? '0 : ((raw & ~clr) | set);
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign masked = raw & ~mask;
  assign irq    = |masked;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe |=> ((raw & $past(set)) == $past(set)));
  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe |=> ((raw & $past(clr) & ~$past(set)) == '0));
  // R11
  wipe_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (raw == '0));
endmodule

// File: rtl/fstat_recover.sv
module fstat_recover #(
  parameter int CYCLES = 8,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left <= '0;
    else if (start && !active) left <= CW'(CYCLES);
    else if (active)           left <= left - CW'(1);
  end

  assign active = (left != '0);

  // R11
  recover_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> active);
  // R11
  recover_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !active) |=> !active);
endmodule

// File: rtl/fstat_unit.sv
module fstat_unit
  import fstat_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [REG_W-1:0]  tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [REG_W-1:0]  rx_data,
  input  logic              seq_busy,
  input  logic              xfer_done,
  input  logic              dma_done,
  input  logic              ser_err,
  input  logic              hbus_err,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic wr, rd, rst_active;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic data_wr, data_rd;
  logic [REG_W-1:0] rx_head, ctrl_q, fsr;
  logic [IRQ_N-1:0] irq_set, irq_clr, raw, mask, masked;

  assign wr = bus_en &  bus_we;
  assign rd = bus_en & ~bus_we;

  assign data_wr = wr && (bus_addr == OFS_DATA) && !rst_active;
  assign data_rd = rd && (bus_addr == OFS_DATA) && !rst_active;
  assign tx_push = data_wr && !tx_full;
  assign rx_pop  = data_rd && !rx_empty;

  assign tx_valid = !tx_empty && !rst_active;
  assign rx_ready = !rx_full && !rst_active;
  assign tx_pop   = tx_valid && tx_ready;
  assign rx_push  = rx_valid && rx_ready;

  fstat_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(rst_active),
    .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  fstat_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rst_active),
    .push(rx_push), .wdata(rx_data), .pop(rx_pop),
    .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  fstat_recover #(.CYCLES(RST_CYCLES)) u_recover (
    .clk(clk), .rst_n(rst_n),
    .start(wr && (bus_addr == OFS_RECOV) && bus_wdata[0]),
    .active(rst_active));

  always_comb begin
    irq_set               = '0;
    irq_set[IRQ_DMA]      = dma_done;
    irq_set[IRQ_SERIAL]   = ser_err;
    irq_set[IRQ_HBUS]     = hbus_err;
    irq_set[IRQ_XFER]     = xfer_done;
    irq_set[IRQ_TX_EMPTY] = tx_pop && (tx_cnt == CW'(1)) && !tx_push;
    irq_set[IRQ_TX_OVER]  = data_wr && tx_full;
    irq_set[IRQ_RX_UNDER] = data_rd && rx_empty;
    irq_set[IRQ_RX_FULL]  = rx_push && (rx_cnt == CW'(DEPTH - 1)) && !rx_pop;
  end

  assign irq_clr = (wr && (bus_addr == OFS_CLR)) ? bus_wdata[IRQ_N-1:0] : '0;

  fstat_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr),
    .wipe(rst_active), .mask_we(wr && (bus_addr == OFS_MASK)),
    .mask_wdata(bus_wdata[IRQ_N-1:0]),
    .raw(raw), .mask(mask), .masked(masked), .irq(irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr && (bus_addr == OFS_CTRL) && !seq_busy) ctrl_q <= bus_wdata;
  end

  assign tx_free = CW'(DEPTH) - tx_cnt;

  always_comb begin
    fsr = '0;
    fsr[FSR_RXLVL_LSB +: LVL_FW] = LVL_FW'(rx_cnt);
    fsr[FSR_TXLVL_LSB +: LVL_FW] = LVL_FW'(tx_free);
    fsr[3] = rx_full;
    fsr[2] = rx_empty;
    fsr[1] = tx_empty;
    fsr[0] = tx_full;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = ctrl_q;
      OFS_MASK:  bus_rdata = REG_W'(mask);
      OFS_RECOV: bus_rdata = REG_W'(rst_active);
      OFS_ISR:   bus_rdata = REG_W'(masked);
      OFS_FSR:   bus_rdata = fsr;
      OFS_SR:    bus_rdata = REG_W'(seq_busy);
      OFS_RAW:   bus_rdata = REG_W'(raw);
      OFS_DATA:  bus_rdata = (rx_empty || rst_active) ? '0 : rx_head;
      default:   bus_rdata = '0;
    endcase
  end

  // R10
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> (ctrl_q == $past(ctrl_q)));
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rst_active && !(wr && bus_addr == OFS_RECOV))
      |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/tb_fstat_unit.sv
module tb_fstat_unit;
  localparam int D  = 4;
  localparam int RC = 3;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 0;
  logic [31:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [31:0] rx_data = '0;
  logic seq_busy = 0, xfer_done = 0, dma_done = 0, ser_err = 0, hbus_err = 0;
  logic irq;

  int checks = 0, fails = 0;
  logic [31:0] tq[$];
  logic [31:0] rq[$];
  logic [7:0] raw_m = '0, mask_m = 8'hFF;
  logic [31:0] ctrl_m = '0;

  always #10 clk = ~clk;

  fstat_unit #(.DEPTH(D), .RST_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .seq_busy(seq_busy), .xfer_done(xfer_done), .dma_done(dma_done),
    .ser_err(ser_err), .hbus_err(hbus_err), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fsr(input int rc, input int tc);
    logic [31:0] v = '0;
    v[20:16] = 5'(rc);
    v[12:8]  = 5'(D - tc);
    v[3] = (rc == D);
    v[2] = (rc == 0);
    v[1] = (tc == 0);
    v[0] = (tc == D);
    return v;
  endfunction

  task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: xfer_done = 1;
      1: hbus_err = 1;
      2: ser_err = 1;
      default: dma_done = 1;
    endcase
    @(posedge clk); #1;
    xfer_done = 0; hbus_err = 0; ser_err = 0; dma_done = 0;
    raw_m[4 + which] = 1'b1;
  endtask

  task automatic data_write(input logic [31:0] d);
    bus_wr(9'h108, d);
    if (tq.size() == D) raw_m[2] = 1'b1;
    else tq.push_back(d);
  endtask

  task automatic data_read();
    logic [31:0] v, e;
    bus_rd(9'h108, v);
    if (rq.size() == 0) begin e = '0; raw_m[1] = 1'b1; check("R5 underflow read", v, e); end
    else begin e = rq.pop_front(); check("R2 rx order", v, e); end
  endtask

  task automatic seq_take();
    logic v; logic [31:0] d;
    @(negedge clk);
    tx_ready = 1;
    #2 v = tx_valid; d = tx_data;
    check("R3 tx_valid", 32'(v), 32'(tq.size() > 0));
    if (v && tq.size() > 0) check("R2 tx order", d, tq[0]);
    @(posedge clk); #1;
    tx_ready = 0;
    if (tq.size() > 0) begin
      void'(tq.pop_front());
      if (tq.size() == 0) raw_m[3] = 1'b1;
    end
  endtask

  task automatic seq_give(input logic [31:0] d);
    logic r;
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    #2 r = rx_ready;
    check("R3 rx_ready", 32'(r), 32'(rq.size() < D));
    @(posedge clk); #1;
    rx_valid = 0;
    if (rq.size() < D) begin
      rq.push_back(d);
      if (rq.size() == D) raw_m[0] = 1'b1;
    end
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    bus_rd(9'h020, v);
    check({"R1 fsr ", tag}, v, exp_fsr(rq.size(), tq.size()));
    bus_rd(9'h028, v);
    check({"R6 raw ", tag}, v, 32'(raw_m));
    bus_rd(9'h01C, v);
    check({"R8 masked ", tag}, v, 32'(raw_m & ~mask_m));
    check({"R8 irq ", tag}, 32'(irq), 32'(|(raw_m & ~mask_m)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R13 reset state
    bus_rd(9'h020, v); check("R13 fsr after reset", v, exp_fsr(0, 0));
    bus_rd(9'h028, v); check("R13 raw after reset", v, 32'h0);
    bus_rd(9'h004, v); check("R13 mask after reset", v, 32'hFF);
    check("R13 irq after reset", 32'(irq), 32'h0);

    // R10 control lock
    bus_wr(9'h000, 32'hA5A5_0001); ctrl_m = 32'hA5A5_0001;
    bus_rd(9'h000, v); check("R10 ctrl stored", v, ctrl_m);
    seq_busy = 1;
    bus_rd(9'h024, v); check("R9 busy bit set", v, 32'h1);
    bus_wr(9'h000, 32'h1234_5678);
    bus_rd(9'h000, v); check("R10 ctrl locked while busy", v, ctrl_m);
    seq_busy = 0;
    bus_rd(9'h024, v); check("R9 busy bit clear", v, 32'h0);
    bus_wr(9'h000, 32'h0000_3F02); ctrl_m = 32'h0000_3F02;
    bus_rd(9'h000, v); check("R10 ctrl after idle", v, ctrl_m);

    // R12 unused offsets
    bus_wr(9'h00C, 32'hFFFF_FFFF);
    bus_rd(9'h00C, v); check("R12 unused reads zero", v, 32'h0);
    bus_rd(9'h100, v); check("R12 unused reads zero", v, 32'h0);
    check_state("after unused write");

    // R4 overflow corner and R5 underflow corner
    for (int i = 0; i < D + 1; i++) data_write(32'hC000_0000 + 32'(i));
    check_state("R4 overflow");
    data_read();
    check_state("R5 underflow");

    // R7 clear with simultaneous set
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 9'h008; bus_wdata = 32'hFFFF_FFFF;
    xfer_done = 1;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0; xfer_done = 0;
    raw_m = 8'h10;
    check_state("R7 set beats clear");

    // R8 mask
    bus_wr(9'h004, 32'h0000_00EF); mask_m = 8'hEF;
    check_state("R8 unmasked done");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 7));
      case (op)
        0, 1: data_write($urandom());
        2:    data_read();
        3:    seq_take();
        4:    seq_give($urandom());
        5:    pulse(int'($urandom_range(0, 3)));
        6: begin
          logic [7:0] c;
          c = 8'($urandom());
          bus_wr(9'h008, 32'(c));
          raw_m = raw_m & ~c;
        end
        default: begin
          mask_m = 8'($urandom());
          bus_wr(9'h004, 32'(mask_m));
        end
      endcase
      check_state("random");
    end

    // R11 soft reset
    for (int i = 0; i < 3; i++) data_write(32'hB000_0000 + 32'(i));
    seq_give(32'h1111_2222);
    pulse(3);
    bus_wr(9'h010, 32'h1);
    for (int i = 0; i < RC; i++) begin
      bus_rd(9'h010, v); check("R11 recovery busy", v, 32'h1);
    end
    bus_rd(9'h010, v); check("R11 recovery self-clears", v, 32'h0);
    tq.delete(); rq.delete(); raw_m = '0;
    check_state("R11 after soft reset");
    bus_rd(9'h000, v); check("R11 ctrl kept", v, ctrl_m);
    bus_rd(9'h004, v); check("R11 mask kept", v, 32'(mask_m));
    data_write(32'hDEAD_BEEF);
    seq_take();
    check_state("R11 fifo usable");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule